// File: doc/BRIEF.md
# Clock Stop and Power-Down Gating Controller

This block sits between an internal CPU-rate clock and a bank of clock output pins. It drives four processor clocks, eight memory clocks, six bus clocks at half the CPU rate and one bus clock that never stops. Every output passes through its own gate. A gate opens only when the run condition for its group holds and the output's enable bit in the configuration word is 1. The gates switch cleanly, so no output ever emits a shortened pulse.

A strap input picks the role of two shared pins. With the strap high, the pins drive the two highest memory clocks and the block ignores every stop and power-down request. With the strap low, the pins turn into active-low inputs. Pin 0 halts the processor clocks and pin 1 halts the gated bus clocks. An active-low power-down input can be asserted at any time, and while the strap is low it parks every output low. On leaving power-down, or on coming out of reset, the outputs wait a programmable relock interval before they run again. The processor clocks then wait a further restart interval of at least three cycles.

Top module: `clkStopGate`

## Requirements
- R1: With the strap low and shared pin 0 low, every processor clock stays low. The memory clocks, the gated bus clocks and the free bus clock keep running.
- R2: After shared pin 0 returns high, the processor clocks show no high phase for at least 3 CPU cycles.
- R3: With the strap low and shared pin 1 low, all six gated bus clocks stay low. The free bus clock and every other output keep running.
- R4: With the strap high, the stop and power-down inputs have no effect. Shared pin 0 then carries memory clock 6 and shared pin 1 carries memory clock 7, each gated by configuration bit 6 or 7 of the memory enable word.
- R5: With the strap low, both shared-pin output enables are 0 and the shared-pin outputs are 0.
- R6: With the strap low and the power-down input low, every clock output goes low. After the input is released, all outputs stay low for at least RELOCK_CYCLES CPU cycles.
- R7: Each bus clock output is high for exactly one CPU cycle and then low for one CPU cycle. Every gated bus clock that runs rises on the same edges as the free bus clock, including after a restart.
- R8: An enable bit of 1 lets its output run and a bit of 0 holds it low. Bit i of each enable word maps to output i of its group.
- R9: A gate changes state only while the CPU clock is low, so each high phase of a processor or memory clock is either entirely present or entirely absent.
- R10: After reset, all outputs stay low for the relock interval and then the enabled outputs run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkCpu | input | 1 | Internal CPU-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 1 | Strap: 1 selects shared pins as memory clocks, 0 selects them as stop inputs |
| pdN | input | 1 | Asynchronous active-low power-down request |
| shPinIn | input | 2 | Shared pins as received: bit 0 stops the processor clocks, bit 1 stops the bus clocks (active low) |
| cfgCpuEn | input | N_CPU | Processor clock enable bits |
| cfgSdrEn | input | N_SDR | Memory clock enable bits; the top two bits belong to the shared pins |
| cfgPciEn | input | N_PCI | Gated bus clock enable bits |
| cfgPciFEn | input | 1 | Free bus clock enable bit |
| cpuClk | output | N_CPU | Gated processor clocks |
| sdramClk | output | N_SDR-2 | Gated memory clocks on dedicated pins |
| pciClk | output | N_PCI | Gated half-rate bus clocks |
| pciClkF | output | 1 | Half-rate bus clock that ignores the bus stop |
| shPinOut | output | 2 | Shared-pin drive value |
| shPinOe | output | 2 | Shared-pin output enable |

## Verification
Assertions watch four things on every cycle: the three-cycle gap between a synchronized processor stop and the restart strobe, the power-down forcing of the run strobes, the one-high-one-low rhythm of the bus clocks with their alignment to the divider, and the quiet shared pins when the strap is low. Other behaviours can only be shown by the bench's scenarios, because each needs a stimulus sequence followed by a measurement. These are the per-bit enable mapping, the effect of each stop on exactly the intended group, the strap turning the stop and power-down pins into don't-cares, the relock silence, the measured restart latency, and the absence of partial high phases.

// File: rtl/clkGatePkg.sv
package clkGatePkg;
  // Run strobes handed from the control to the datapath
  typedef struct packed {
    logic cpuRun;
    logic sdrRun;
    logic pciRun;
    logic pciFRun;
  } gateStrobes_t;

  localparam int SHARED_PINS = 2;
endpackage

// File: rtl/gateSync.sv
module gateSync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : gStage
    if (s == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain[0] <= '0;
        else       chain[0] <= din;
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain[s] <= '0;
        else       chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/gateCtrl.sv
module gateCtrl
  import clkGatePkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int RESTART_CYCLES = 3,
  parameter int RELOCK_CYCLES  = 16
) (
  input  logic         clkCpu,
  input  logic         rstN,
  input  logic         modeSel,
  input  logic         pdN,
  input  logic         cpuStopN,
  input  logic         pciStopN,
  output gateStrobes_t strobes
);
  localparam int RELOCK_W  = $clog2(RELOCK_CYCLES + 1);
  localparam int RESTART_W = $clog2(RESTART_CYCLES + 1);
  localparam logic [RELOCK_W-1:0]  RELOCK_LAST  = RELOCK_W'(RELOCK_CYCLES);
  localparam logic [RESTART_W-1:0] RESTART_LAST = RESTART_W'(RESTART_CYCLES);

  logic [2:0] reqRaw, reqSync;
  logic cpuStopSync, pciStopSync, pdSync;
  logic [RELOCK_W-1:0]  relockCnt;
  logic [RESTART_W-1:0] cpuCnt;
  logic locked;

  // Requests count only in stop-input mode
  assign reqRaw = {~modeSel & ~pdN, ~modeSel & ~pciStopN, ~modeSel & ~cpuStopN};

  gateSync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_reqSync (
    .clk (clkCpu),
    .rstN(rstN),
    .din (reqRaw),
    .dout(reqSync)
  );

  assign cpuStopSync = reqSync[0];
  assign pciStopSync = reqSync[1];
  assign pdSync      = reqSync[2];
  assign locked      = (relockCnt == RELOCK_LAST);

  // Relock interval after reset or power-down
  always_ff @(posedge clkCpu or negedge rstN)
    if (!rstN)       relockCnt <= '0;
    else if (pdSync) relockCnt <= '0;
    else if (!locked) relockCnt <= relockCnt + 1'b1;

  // Processor restart latency
  always_ff @(posedge clkCpu or negedge rstN)
    if (!rstN)                         cpuCnt <= '0;
    else if (cpuStopSync || !locked)   cpuCnt <= '0;
    else if (cpuCnt != RESTART_LAST)   cpuCnt <= cpuCnt + 1'b1;

  always_comb begin
    strobes.cpuRun  = (cpuCnt == RESTART_LAST);
    strobes.sdrRun  = locked;
    strobes.pciRun  = locked & ~pciStopSync;
    strobes.pciFRun = locked;
  end

  AST_CPU_RESTART_GAP: assert property (@(posedge clkCpu) disable iff (!rstN)
    strobes.cpuRun |-> (!$past(cpuStopSync, 1) && !$past(cpuStopSync, 2) && !$past(cpuStopSync, 3))); // R2

  AST_PD_FORCES_LOW: assert property (@(posedge clkCpu) disable iff (!rstN)
    pdSync |=> (!strobes.sdrRun && !strobes.pciFRun && !strobes.pciRun)); // R6
endmodule

// File: rtl/gateDatapath.sv
module gateDatapath
  import clkGatePkg::*;
#(
  parameter int N_CPU = 4,
  parameter int N_SDR = 8,
  parameter int N_PCI = 6
) (
  input  logic                         clkCpu,
  input  logic                         rstN,
  input  logic                         modeSel,
  input  gateStrobes_t                 strobes,
  input  logic [N_CPU-1:0]             cfgCpuEn,
  input  logic [N_SDR-1:0]             cfgSdrEn,
  input  logic [N_PCI-1:0]             cfgPciEn,
  input  logic                         cfgPciFEn,
  output logic [N_CPU-1:0]             cpuClk,
  output logic [N_SDR-SHARED_PINS-1:0] sdramClk,
  output logic [N_PCI-1:0]             pciClk,
  output logic                         pciClkF,
  output logic [SHARED_PINS-1:0]       shPinOut,
  output logic [SHARED_PINS-1:0]       shPinOe
);
  localparam int N_FIX = N_SDR - SHARED_PINS;

  logic [N_CPU-1:0] cpuEnQ;
  logic [N_SDR-1:0] sdrEnQ;
  logic [N_PCI-1:0] pciQ;
  logic pciDiv, pciFQ;

  // Enables move on the falling edge, while the clock is low
  always_ff @(negedge clkCpu or negedge rstN)
    if (!rstN) begin
      cpuEnQ <= '0;
      sdrEnQ <= '0;
    end else begin
      cpuEnQ <= {N_CPU{strobes.cpuRun}} & cfgCpuEn;
      sdrEnQ <= {N_SDR{strobes.sdrRun}} & cfgSdrEn;
    end

  for (genvar i = 0; i < N_CPU; i++) begin : gCpuGate
    assign cpuClk[i] = clkCpu & cpuEnQ[i];
  end

  for (genvar i = 0; i < N_FIX; i++) begin : gSdrGate
    assign sdramClk[i] = clkCpu & sdrEnQ[i];
  end

  for (genvar i = 0; i < SHARED_PINS; i++) begin : gSharedPin
    assign shPinOut[i] = modeSel & clkCpu & sdrEnQ[N_FIX+i];
    assign shPinOe[i]  = modeSel;
  end

  // Half-rate bus clocks: a pulse starts only at a divider rising edge
  always_ff @(posedge clkCpu or negedge rstN)
    if (!rstN) begin
      pciDiv <= 1'b0;
      pciQ   <= '0;
      pciFQ  <= 1'b0;
    end else begin
      pciDiv <= ~pciDiv;
      pciQ   <= pciDiv ? '0 : ({N_PCI{strobes.pciRun}} & cfgPciEn);
      pciFQ  <= ~pciDiv & strobes.pciFRun & cfgPciFEn;
    end

  assign pciClk  = pciQ;
  assign pciClkF = pciFQ;

  AST_PCI_HALF_RATE: assert property (@(posedge clkCpu) disable iff (!rstN)
    (pciFQ || (|pciQ)) |=> (!pciFQ && (pciQ == '0))); // R7

  AST_PCI_PHASE_ALIGN: assert property (@(posedge clkCpu) disable iff (!rstN)
    (pciFQ || (|pciQ)) |-> pciDiv); // R7
endmodule

// File: rtl/clkStopGate.sv
module clkStopGate
  import clkGatePkg::*;
#(
  parameter int N_CPU          = 4,
  parameter int N_SDR          = 8,
  parameter int N_PCI          = 6,
  parameter int SYNC_STAGES    = 2,
  parameter int RESTART_CYCLES = 3,
  parameter int RELOCK_CYCLES  = 16
) (
  input  logic                   clkCpu,
  input  logic                   rstN,
  input  logic                   modeSel,
  input  logic                   pdN,
  input  logic [1:0]             shPinIn,
  input  logic [N_CPU-1:0]       cfgCpuEn,
  input  logic [N_SDR-1:0]       cfgSdrEn,
  input  logic [N_PCI-1:0]       cfgPciEn,
  input  logic                   cfgPciFEn,
  output logic [N_CPU-1:0]       cpuClk,
  output logic [N_SDR-3:0]       sdramClk,
  output logic [N_PCI-1:0]       pciClk,
  output logic                   pciClkF,
  output logic [1:0]             shPinOut,
  output logic [1:0]             shPinOe
);
  gateStrobes_t strobes;

  gateCtrl #(
    .SYNC_STAGES   (SYNC_STAGES),
    .RESTART_CYCLES(RESTART_CYCLES),
    .RELOCK_CYCLES (RELOCK_CYCLES)
  ) u_ctrl (
    .clkCpu  (clkCpu),
    .rstN    (rstN),
    .modeSel (modeSel),
    .pdN     (pdN),
    .cpuStopN(shPinIn[0]),
    .pciStopN(shPinIn[1]),
    .strobes (strobes)
  );

  gateDatapath #(
    .N_CPU(N_CPU),
    .N_SDR(N_SDR),
    .N_PCI(N_PCI)
  ) u_dp (
    .clkCpu   (clkCpu),
    .rstN     (rstN),
    .modeSel  (modeSel),
    .strobes  (strobes),
    .cfgCpuEn (cfgCpuEn),
    .cfgSdrEn (cfgSdrEn),
    .cfgPciEn (cfgPciEn),
    .cfgPciFEn(cfgPciFEn),
    .cpuClk   (cpuClk),
    .sdramClk (sdramClk),
    .pciClk   (pciClk),
    .pciClkF  (pciClkF),
    .shPinOut (shPinOut),
    .shPinOe  (shPinOe)
  );

  AST_SHARED_QUIET: assert property (@(posedge clkCpu) disable iff (!rstN)
    !modeSel |-> (shPinOe == 2'b00 && shPinOut == 2'b00)); // R5
endmodule

// File: tb/clkStopGate_tb.sv
module clkStopGate_tb;
  localparam int RELOCK = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeSel = 1'b0;
  logic pdN = 1'b1;
  logic [1:0] shPinIn = 2'b11;
  logic [3:0] cfgCpuEn = 4'hF;
  logic [7:0] cfgSdrEn = 8'hFF;
  logic [5:0] cfgPciEn = 6'h3F;
  logic cfgPciFEn = 1'b1;
  logic [3:0] cpuClk;
  logic [5:0] sdramClk;
  logic [5:0] pciClk;
  logic pciClkF;
  logic [1:0] shPinOut, shPinOe;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  clkStopGate #(.RELOCK_CYCLES(RELOCK)) u_dut (
    .clkCpu(clk), .rstN(rstN), .modeSel(modeSel), .pdN(pdN), .shPinIn(shPinIn),
    .cfgCpuEn(cfgCpuEn), .cfgSdrEn(cfgSdrEn), .cfgPciEn(cfgPciEn), .cfgPciFEn(cfgPciFEn),
    .cpuClk(cpuClk), .sdramClk(sdramClk), .pciClk(pciClk), .pciClkF(pciClkF),
    .shPinOut(shPinOut), .shPinOe(shPinOe)
  );

  // {mode, cpuStopN, pciStopN, pdN, cpuEn[3:0], pciEn[5:0], sdrEn[7:0], pciFEn}
  localparam logic [22:0] VEC [8] = '{
    {1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 6'h3F, 8'hFF, 1'b1},
    {1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 6'h3F, 8'hFF, 1'b1},
    {1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'h3F, 8'hFF, 1'b1},
    {1'b0, 1'b1, 1'b1, 1'b0, 4'hF, 6'h3F, 8'hFF, 1'b1},
    {1'b1, 1'b0, 1'b0, 1'b0, 4'hF, 6'h3F, 8'hFF, 1'b1},
    {1'b0, 1'b1, 1'b1, 1'b1, 4'h5, 6'h2A, 8'hA5, 1'b0},
    {1'b1, 1'b1, 1'b1, 1'b1, 4'hA, 6'h15, 8'h5A, 1'b1},
    {1'b0, 1'b0, 1'b0, 1'b1, 4'h3, 6'h3F, 8'h0F, 1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic waitCycles(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  // OR of outputs sampled in the high phase over n cycles
  task automatic measure(input int n, output logic [3:0] aCpu, output logic [5:0] aSdr,
                         output logic [5:0] aPci, output logic aF, output logic [1:0] aSh);
    aCpu = '0; aSdr = '0; aPci = '0; aF = 1'b0; aSh = '0;
    for (int k = 0; k < n; k++) begin
      tick();
      aCpu |= cpuClk; aSdr |= sdramClk; aPci |= pciClk; aF |= pciClkF; aSh |= shPinOut;
    end
  endtask

  logic [3:0] mCpu; logic [5:0] mSdr; logic [5:0] mPci; logic mF; logic [1:0] mSh;

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    waitCycles(4);
    @(negedge clk); rstN = 1'b1;
    // R10: quiet during relock after reset
    measure(10, mCpu, mSdr, mPci, mF, mSh);
    check({mCpu, mSdr, mPci, mF, mSh} == '0, "R10 outputs low after reset",
          int'({mCpu, mSdr, mPci, mF, mSh}), 0);
    waitCycles(20);
    measure(8, mCpu, mSdr, mPci, mF, mSh);
    check({mCpu, mSdr, mPci, mF} == {4'hF, 6'h3F, 6'h3F, 1'b1}, "R10 outputs run after relock",
          int'({mCpu, mSdr, mPci, mF}), int'({4'hF, 6'h3F, 6'h3F, 1'b1}));

    // Table walk
    for (int v = 0; v < 8; v++) begin
      logic m, cN, pN, dN, fE, act, cpuOn, pciOn;
      logic [3:0] eC; logic [5:0] eP; logic [7:0] eS;
      {m, cN, pN, dN, eC, eP, eS, fE} = VEC[v];
      modeSel = m; shPinIn = {pN, cN}; pdN = dN;
      cfgCpuEn = eC; cfgPciEn = eP; cfgSdrEn = eS; cfgPciFEn = fE;
      act = m | dN;
      cpuOn = act & (m | cN);
      pciOn = act & (m | pN);
      waitCycles(40);
      measure(8, mCpu, mSdr, mPci, mF, mSh);
      check(mCpu == (cpuOn ? eC : 4'h0), $sformatf("R1 cpu clocks vec%0d", v),
            int'(mCpu), int'(cpuOn ? eC : 4'h0));
      check(mSdr == (act ? eS[5:0] : 6'h0), $sformatf("R8 memory clocks vec%0d", v),
            int'(mSdr), int'(act ? eS[5:0] : 6'h0));
      check(mPci == (pciOn ? eP : 6'h0), $sformatf("R3 bus clocks vec%0d", v),
            int'(mPci), int'(pciOn ? eP : 6'h0));
      check(mF == (act & fE), $sformatf("R3 free bus clock vec%0d", v),
            int'(mF), int'(act & fE));
      check(mSh == (m ? eS[7:6] : 2'b00), $sformatf("R4 shared pin clocks vec%0d", v),
            int'(mSh), int'(m ? eS[7:6] : 2'b00));
      check(shPinOe == {m, m}, $sformatf("R5 shared pin enables vec%0d", v),
            int'(shPinOe), int'({m, m}));
    end

    // R6: power-down then relock silence
    modeSel = 1'b0; shPinIn = 2'b11; pdN = 1'b1;
    cfgCpuEn = 4'hF; cfgSdrEn = 8'hFF; cfgPciEn = 6'h3F; cfgPciFEn = 1'b1;
    waitCycles(40);
    #1 pdN = 1'b0;
    waitCycles(10);
    measure(6, mCpu, mSdr, mPci, mF, mSh);
    check({mCpu, mSdr, mPci, mF, mSh} == '0, "R6 all low in power-down",
          int'({mCpu, mSdr, mPci, mF, mSh}), 0);
    pdN = 1'b1;
    measure(RELOCK, mCpu, mSdr, mPci, mF, mSh);
    check({mCpu, mSdr, mPci, mF, mSh} == '0, "R6 low during relock",
          int'({mCpu, mSdr, mPci, mF, mSh}), 0);
    waitCycles(20);
    measure(8, mCpu, mSdr, mPci, mF, mSh);
    check(mCpu == 4'hF && mF, "R6 running after relock", int'({mCpu, mF}), int'({4'hF, 1'b1}));

    // R2 and R9: stop then measure restart latency, watching for partial high phases
    begin
      int partial = 0;
      int lat = 0;
      shPinIn[0] = 1'b0;
      for (int k = 0; k < 12; k++) begin
        logic [3:0] a, b;
        @(posedge clk); #1 a = cpuClk; #3 b = cpuClk;
        if (a != b) partial++;
      end
      check(cpuClk == 4'h0, "R1 cpu clocks halted", int'(cpuClk), 0);
      shPinIn[0] = 1'b1;
      for (int k = 1; k <= 20; k++) begin
        logic [3:0] a, b;
        @(posedge clk); #1 a = cpuClk; #3 b = cpuClk;
        if (a != b) partial++;
        if (a != 4'h0 && lat == 0) lat = k;
      end
      check(lat >= 3 && lat <= 10, "R2 restart latency", lat, 6);
      check(partial == 0, "R9 no partial high phase", partial, 0);
    end

    // R7: bus clocks after a stop and restart
    begin
      int highs = 0;
      int dbl = 0;
      int misal = 0;
      logic prevF = 1'b0;
      shPinIn[1] = 1'b0;
      waitCycles(12);
      shPinIn[1] = 1'b1;
      waitCycles(12);
      for (int k = 0; k < 12; k++) begin
        tick();
        if (pciClkF) highs++;
        if (pciClkF && prevF) dbl++;
        if (pciClk != {6{pciClkF}}) misal++;
        prevF = pciClkF;
      end
      check(highs == 6 && dbl == 0, "R7 half-rate rhythm", highs * 100 + dbl, 600);
      check(misal == 0, "R7 bus clocks aligned after restart", misal, 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule